// File: doc/BRIEF.md
# Serial Receiver with Selectable Error Reporting

This block deserialises an asynchronous serial line into bytes. An oversampling tick, sixteen per bit period, paces it. Each frame has one start bit, eight data bits sent least significant bit first, an optional even parity bit and one stop bit. Every received byte goes into a small receive queue together with three flags of its own: line break, framing error and parity error.

A command decoder drives single-cycle strobes into the block. These strobes turn the receiver on and off, abort reception and empty the queue, clear the sticky error bits and clear the break-change flag. Two further strobes choose when the per-byte flags reach the status byte. In the default mode a flag reaches the status byte when its byte is read out of the queue. In accumulation mode it reaches the status byte as soon as the byte is written into the queue. Accumulation mode reports errors earlier, but it no longer shows which queued byte was bad.

The host reads the oldest byte from `rd_data`, which always shows the head of the queue. A one-cycle `rd_en` pops that byte.

Top module: `uart_rx_errstat`

## Requirements
- R1: After the synchronous reset `rst`, the receiver is off (`rx_on`=0), the queue is empty, `status` is 0x00, `brk_chg` is 0 and the error reporting mode is read-time.
- R2: While off, the receiver ignores the line. While on, a tick with `rxd` low starts a candidate start bit. The bit is accepted only if `rxd` is still low on the 8th tick after that. If it is not, the receiver goes back to searching and stores nothing.
- R3: A frame is 8 data bits LSB first, then an even parity bit when `par_en`=1, then one stop bit. Each bit is sampled at its midpoint. Bytes are queued in arrival order. `rd_data` shows the oldest byte, `rd_valid` (also `status[0]`) is 1 when the queue is not empty, and `status[1]` is 1 when it is full. `rd_en` pops one byte. `rd_en` on an empty queue changes nothing.
- R4: `cmd_disable` turns the receiver off at once and drops the byte being received. The queued bytes and `status[7:4]` are kept. After `cmd_enable`, new bytes go in behind the kept ones. If both strobes are high in the same cycle, disable wins.
- R5: `cmd_reset_rx` empties the queue, discards all unread bytes and aborts the frame in progress. `rx_on` and `status[7:4]` are unchanged.
- R6: A byte's framing flag is set when its stop bit is sampled low. Its parity flag is set when `par_en`=1 and the parity bit does not make the total count of ones even. A break byte is one whose data, parity (if used) and stop bits are all low. It is stored as 0x00 with only the break flag set.
- R7: In read-time mode, popping a byte ORs its break, framing and parity flags into `status[7]`, `status[6]` and `status[5]`. These bits are sticky.
- R8: After `cmd_accum_on` the flags are ORed into `status[7:5]` when the byte is written into the queue. `cmd_accum_off` returns to read-time mode, and off wins if both strobes come together.
- R9: A byte that completes while the queue is full, with no pop in that cycle, is dropped and sets the sticky overrun bit `status[4]`. Its own flags are not recorded.
- R10: `cmd_clr_err` clears `status[7:4]`. A set that occurs in the same cycle wins.
- R11: `brk_chg` is set when a break byte is received and again when the line next returns high. `cmd_clr_brk_chg` clears it, and a new change in the same cycle wins.
- R12: After a byte with a low stop bit, the receiver waits for the line to go high before it searches for the next start bit. A held break therefore yields exactly one break byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Expect an even parity bit |
| cmd_enable | input | 1 | Strobe: receiver on |
| cmd_disable | input | 1 | Strobe: receiver off, abort frame |
| cmd_reset_rx | input | 1 | Strobe: empty queue, abort frame |
| cmd_clr_err | input | 1 | Strobe: clear status[7:4] |
| cmd_clr_brk_chg | input | 1 | Strobe: clear brk_chg |
| cmd_accum_on | input | 1 | Strobe: entry-time error reporting |
| cmd_accum_off | input | 1 | Strobe: read-time error reporting |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest queued byte |
| rd_valid | output | 1 | Queue not empty |
| status | output | 8 | [7] break, [6] framing, [5] parity, [4] overrun, [3:2] zero, [1] full, [0] not empty |
| brk_chg | output | 1 | Break state changed |
| rx_on | output | 1 | Receiver enabled |

## Verification
The assertions assume that `rxd` is synchronous to `clk`, and that each command strobe lasts a single cycle. The bench meets both: it changes the line and every strobe only on the falling clock edge, and it issues one command per pulse. The bench keeps `tick16` at every second cycle, so a bit period is exactly 32 clocks and the midpoint samples fall well inside each bit. The glitch, break and mid-frame disable cases are timed in whole bit periods from that cadence.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OS_RATE   = 16;
    localparam int OS_W      = $clog2(OS_RATE);
    localparam int MID_TICK  = OS_RATE / 2 - 1;
    localparam int LAST_TICK = OS_RATE - 1;
    localparam int DATA_BITS = 8;
    localparam int IDX_W     = $clog2(DATA_BITS);

    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rx_flags_t;

    typedef struct packed {
        rx_flags_t              flags;
        logic [DATA_BITS-1:0]   data;
    } rx_char_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    function automatic logic parity_bad(input logic [DATA_BITS-1:0] d, input logic p);
        return (^d) ^ p;
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    input  logic     par_en,
    input  logic     cmd_enable,
    input  logic     cmd_disable,
    input  logic     cmd_abort,
    output logic     rx_on,
    output logic     brk_active,
    output logic     out_valid,
    output rx_char_t out_char
);

    rx_state_t            state;
    logic [OS_W-1:0]      cnt;
    logic [IDX_W-1:0]     bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bit;
    logic                 stop_brk;

    assign stop_brk = (shreg == '0) && !rxd && (!par_en || !par_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_on <= 1'b0;
        end else if (cmd_disable) begin
            rx_on <= 1'b0;
        end else if (cmd_enable) begin
            rx_on <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        out_valid <= 1'b0;
        if (rst || cmd_disable || cmd_abort) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            if (rst) begin
                shreg    <= '0;
                par_bit  <= 1'b0;
                out_char <= '0;
            end
        end else if (tick && rx_on) begin
            unique case (state)
                RX_IDLE: begin
                    if (!rxd) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == OS_W'(MID_TICK)) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        par_bit <= 1'b0;
                        state   <= rxd ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == OS_W'(LAST_TICK)) begin
                        cnt     <= '0;
                        shreg   <= {rxd, shreg[DATA_BITS-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == IDX_W'(DATA_BITS - 1)) begin
                            state <= par_en ? RX_PAR : RX_STOP;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (cnt == OS_W'(LAST_TICK)) begin
                        cnt     <= '0;
                        par_bit <= rxd;
                        state   <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == OS_W'(LAST_TICK)) begin
                        cnt                <= '0;
                        out_valid          <= 1'b1;
                        out_char.data      <= stop_brk ? '0 : shreg;
                        out_char.flags.brk <= stop_brk;
                        out_char.flags.fe  <= !rxd && !stop_brk;
                        out_char.flags.pe  <= !stop_brk && par_en && parity_bad(shreg, par_bit);
                        state              <= rxd ? RX_IDLE : RX_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (rxd) begin
                        state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd_abort) begin
            brk_active <= 1'b0;
        end else if (tick && rx_on && state == RX_STOP && cnt == OS_W'(LAST_TICK) && stop_brk) begin
            brk_active <= 1'b1;
        end else if (tick && rxd) begin
            brk_active <= 1'b0;
        end
    end

    AST_DISABLE_ABORT: assert property (@(posedge clk) disable iff (rst)
        cmd_disable |=> (!rx_on && state == RX_IDLE && !out_valid)) else $error("disable did not abort"); // R4

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == RX_HOLD && !rxd && !cmd_disable && !cmd_abort) |=> (state == RX_HOLD)) else $error("left hold while line low"); // R12

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !rx_on |=> !out_valid) else $error("byte emitted while off"); // R2

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     wr_en,
    input  rx_char_t wr_char,
    input  logic     rd_en,
    output rx_char_t head,
    output logic     empty,
    output logic     full,
    output logic     pushed,
    output logic     popped,
    output logic     dropped
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_char_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign popped  = rd_en && !empty && !clear;
    assign pushed  = wr_en && !clear && (!full || popped);
    assign dropped = wr_en && !clear && full && !popped;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (pushed) begin
            mem[wr_ptr] <= wr_char;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pushed) wr_ptr <= ptr_inc(wr_ptr);
            if (popped) rd_ptr <= ptr_inc(rd_ptr);
            if (pushed && !popped)      count <= count + 1'b1;
            else if (popped && !pushed) count <= count - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)) else $error("queue count past depth"); // R9

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clear |=> empty) else $error("reset_rx left data"); // R5

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !wr_en && !clear) |=> empty) else $error("read on empty moved state"); // R3

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_accum_on,
    input  logic       cmd_accum_off,
    input  logic       cmd_clr_err,
    input  logic       cmd_clr_brk_chg,
    input  logic       popped,
    input  rx_flags_t  pop_flags,
    input  logic       pushed,
    input  rx_flags_t  push_flags,
    input  logic       dropped,
    input  logic       brk_active,
    output logic [3:0] err,
    output logic       brk_chg
);

    logic      accum;
    logic      brk_prev;
    rx_flags_t set_flags;

    always_comb begin
        set_flags = '0;
        if (accum) begin
            if (pushed) set_flags = push_flags;
        end else begin
            if (popped) set_flags = pop_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            accum <= 1'b0;
        end else if (cmd_accum_off) begin
            accum <= 1'b0;
        end else if (cmd_accum_on) begin
            accum <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err      <= '0;
            brk_chg  <= 1'b0;
            brk_prev <= 1'b0;
        end else begin
            err      <= (cmd_clr_err ? 4'b0000 : err) |
                        {set_flags.brk, set_flags.fe, set_flags.pe, dropped};
            brk_chg  <= (cmd_clr_brk_chg ? 1'b0 : brk_chg) | (brk_active ^ brk_prev);
            brk_prev <= brk_active;
        end
    end

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        dropped |=> err[0]) else $error("overrun not flagged"); // R9

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_clr_err && !dropped && !popped && !pushed) |=> (err == 4'b0000)) else $error("error bits not cleared"); // R10

    AST_BRK_CHG_SET: assert property (@(posedge clk) disable iff (rst)
        !$stable(brk_active) |=> brk_chg) else $error("break change missed"); // R11

endmodule

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat
    import uart_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       par_en,
    input  logic       cmd_enable,
    input  logic       cmd_disable,
    input  logic       cmd_reset_rx,
    input  logic       cmd_clr_err,
    input  logic       cmd_clr_brk_chg,
    input  logic       cmd_accum_on,
    input  logic       cmd_accum_off,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic [7:0] status,
    output logic       brk_chg,
    output logic       rx_on
);

    logic       brk_active;
    logic       char_valid;
    rx_char_t   char_in;
    rx_char_t   head;
    logic       empty, full, pushed, popped, dropped;
    logic [3:0] err;

    uart_rx_frame u_frame (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick16),
        .rxd         (rxd),
        .par_en      (par_en),
        .cmd_enable  (cmd_enable),
        .cmd_disable (cmd_disable),
        .cmd_abort   (cmd_reset_rx),
        .rx_on       (rx_on),
        .brk_active  (brk_active),
        .out_valid   (char_valid),
        .out_char    (char_in)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .clear   (cmd_reset_rx),
        .wr_en   (char_valid),
        .wr_char (char_in),
        .rd_en   (rd_en),
        .head    (head),
        .empty   (empty),
        .full    (full),
        .pushed  (pushed),
        .popped  (popped),
        .dropped (dropped)
    );

    uart_rx_status u_status (
        .clk             (clk),
        .rst             (rst),
        .cmd_accum_on    (cmd_accum_on),
        .cmd_accum_off   (cmd_accum_off),
        .cmd_clr_err     (cmd_clr_err),
        .cmd_clr_brk_chg (cmd_clr_brk_chg),
        .popped          (popped),
        .pop_flags       (head.flags),
        .pushed          (pushed),
        .push_flags      (char_in.flags),
        .dropped         (dropped),
        .brk_active      (brk_active),
        .err             (err),
        .brk_chg         (brk_chg)
    );

    assign rd_data  = head.data;
    assign rd_valid = !empty;
    assign status   = {err, 2'b00, full, !empty};

    AST_RESET_RX_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (cmd_reset_rx && !cmd_clr_err) |=> (status[7:4] == $past(status[7:4]))) else $error("reset_rx touched errors"); // R5

endmodule

// File: tb/uart_rx_errstat_test.sv
module uart_rx_errstat_test;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;
    localparam int DEPTH      = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset_rx = 1'b0;
    logic       cmd_clr_err = 1'b0, cmd_clr_brk_chg = 1'b0;
    logic       cmd_accum_on = 1'b0, cmd_accum_off = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [7:0] status;
    logic       brk_chg;
    logic       rx_on;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] expq[$];

    uart_rx_errstat #(.FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .par_en(par_en),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset_rx(cmd_reset_rx),
        .cmd_clr_err(cmd_clr_err), .cmd_clr_brk_chg(cmd_clr_brk_chg),
        .cmd_accum_on(cmd_accum_on), .cmd_accum_off(cmd_accum_off),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .status(status), .brk_chg(brk_chg), .rx_on(rx_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input int which);
        @(negedge clk);
        case (which)
            0: cmd_enable = 1'b1;
            1: cmd_disable = 1'b1;
            2: cmd_reset_rx = 1'b1;
            3: cmd_clr_err = 1'b1;
            4: cmd_clr_brk_chg = 1'b1;
            5: cmd_accum_on = 1'b1;
            default: cmd_accum_off = 1'b1;
        endcase
        @(negedge clk);
        {cmd_enable, cmd_disable, cmd_reset_rx, cmd_clr_err, cmd_clr_brk_chg, cmd_accum_on, cmd_accum_off} = '0;
    endtask

    task automatic line(input logic v, input int bits);
        rxd = v;
        clks(bits * BIT_CLKS);
    endtask

    // driver: sends one frame, queues the expected byte when it should be stored
    task automatic send(input logic [7:0] d, input bit bad_par, input logic stop_v, input bit expect_it);
        @(negedge clk);
        line(1'b0, 1);
        for (int i = 0; i < 8; i++) line(d[i], 1);
        if (par_en) line((^d) ^ bad_par, 1);
        line(stop_v, 1);
        line(1'b1, 1);
        if (expect_it) expq.push_back(d);
    endtask

    // monitor: pops every byte the design presents and compares with the queue
    task automatic drain(input string req);
        while (rd_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, req, rd_data, 0);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                check(rd_data == e, req, rd_data, e);
            end
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            @(negedge clk);
        end
        check(expq.size() == 0, req, expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clks(4);
        rst = 1'b0;
        clks(2);
        // R1 reset state
        check(status == 8'h00, "R1 status", status, 0);
        check(!rd_valid && !brk_chg && !rx_on, "R1 flags", {rd_valid, brk_chg, rx_on}, 0);

        // R2 off receiver ignores the line
        send(8'h77, 0, 1'b1, 0);
        clks(8);
        check(!rd_valid, "R2 off ignores", rd_valid, 0);

        cmd(0);
        check(rx_on, "R4 enable", rx_on, 1);
        // R3 basic frames, no parity
        send(8'hA5, 0, 1'b1, 1);
        send(8'h3C, 0, 1'b1, 1);
        check(status[0] && !status[1], "R3 not empty", status[1:0], 1);
        drain("R3 order");
        check(status == 8'h00, "R7 clean status", status, 0);

        // R2 glitch shorter than half a bit
        @(negedge clk);
        rxd = 1'b0; clks(6); rxd = 1'b1;
        clks(12 * BIT_CLKS);
        check(!rd_valid, "R2 glitch rejected", rd_valid, 0);

        // R3 read on empty changes nothing
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
        check(status == 8'h00, "R3 empty read", status, 0);
        send(8'h81, 0, 1'b1, 1);
        drain("R3 after empty read");

        // R6/R7 parity, read-time reporting
        par_en = 1'b1;
        send(8'h5A, 0, 1'b1, 1);
        send(8'h01, 1, 1'b1, 1);
        check(status[7:4] == 4'h0, "R7 not yet read", status[7:4], 0);
        drain("R6 parity bytes");
        check(status[7:4] == 4'b0010, "R7 parity on read", status[7:4], 4'b0010);
        cmd(3);
        check(status[7:4] == 4'h0, "R10 clear", status[7:4], 0);

        // R8 accumulation mode
        cmd(5);
        send(8'h02, 1, 1'b1, 1);
        check(status[7:4] == 4'b0010, "R8 parity at entry", status[7:4], 4'b0010);
        send(8'h04, 0, 1'b0, 1);
        check(status[7:4] == 4'b0110, "R8 framing at entry", status[7:4], 4'b0110);
        drain("R8 bytes");
        cmd(3);
        cmd(6);
        par_en = 1'b0;
        send(8'h10, 0, 1'b0, 1);
        check(status[7:4] == 4'h0, "R8 off back to read-time", status[7:4], 0);
        drain("R6 framing byte");
        check(status[7:4] == 4'b0100, "R6 framing flag", status[7:4], 4'b0100);
        cmd(3);

        // R4 disable mid-frame keeps queue
        send(8'h11, 0, 1'b1, 1);
        @(negedge clk);
        line(1'b0, 1);
        for (int i = 0; i < 4; i++) line(1'b1, 1);
        cmd(1);
        for (int i = 0; i < 4; i++) line(1'b0, 1);
        line(1'b1, 2);
        check(!rx_on, "R4 off", rx_on, 0);
        check(status == 8'h01, "R4 queue and status kept", status, 8'h01);
        cmd(0);
        send(8'h22, 0, 1'b1, 1);
        drain("R4 append");

        // R5 receiver reset
        send(8'h44, 0, 1'b1, 0);
        send(8'h55, 0, 1'b1, 0);
        cmd(2);
        check(!rd_valid && rx_on, "R5 emptied", {rd_valid, rx_on}, 1);
        send(8'h33, 0, 1'b1, 1);
        drain("R5 after reset");

        // R9 overrun
        for (int i = 0; i < DEPTH; i++) send(8'h60 + 8'(i), 0, 1'b1, 1);
        check(status[1] && status[4] == 1'b0, "R9 full no overrun", status, 8'h03);
        send(8'hEE, 1, 1'b0, 0);
        check(status[7:4] == 4'b0001, "R9 overrun only", status[7:4], 4'b0001);
        drain("R9 kept bytes");
        cmd(3);

        // R11/R12 break
        @(negedge clk);
        rxd = 1'b0;
        clks(11 * BIT_CLKS);
        check(brk_chg, "R11 break start", brk_chg, 1);
        cmd(4);
        check(!brk_chg, "R11 clear", brk_chg, 0);
        clks(13 * BIT_CLKS);
        check(!brk_chg, "R12 held break no change", brk_chg, 0);
        rxd = 1'b1;
        clks(2 * BIT_CLKS);
        check(brk_chg, "R11 break end", brk_chg, 1);
        expq.push_back(8'h00);
        drain("R12 single break byte");
        check(status[7:4] == 4'b1000, "R6 break flag only", status[7:4], 4'b1000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule